// File: doc/BRIEF.md
# SpaceWire Receive Packet Router

This block takes the character stream from a SpaceWire receiver and decides, packet by packet, where the N-Chars go. The possible destinations are up to four receive DMA channels and an optional RMAP command handler. In normal mode, the first byte of a packet is the node address. It is compared with the address of every enabled channel, and the lowest-indexed channel that matches receives the packet. A packet that matches no channel is discarded. A packet that ends before its second byte is also discarded.

A promiscuous control input changes this. Address matching is skipped, and every data character goes to the lowest-numbered enabled channel, even when the packet ends early. Two rules still apply in promiscuous mode. First, the per-channel maximum receive length is enforced: bytes beyond the limit are dropped, and the end marker carries a truncation flag. Second, when the RMAP handler is enabled, RMAP commands (protocol byte 0x01 in the second position) are diverted to the handler.

Every packet byte reaches its destination one input character late, because the first byte is held until the routing decision is made. The end marker follows one cycle after the last data byte. All destinations share one data output, and a one-hot write strobe selects the destination. A sticky flag records that a packet was thrown away because no channel was enabled.

Top module: `spw_rx_router`

## Requirements
- R1: While reset is held and right after it, no write strobe is active and the no-channel flag is 0.
- R2: In normal mode, the first byte is compared with the address of each enabled channel, and the lowest-indexed match receives every data byte in arrival order, followed by one end marker (end_o=1).
- R3: In normal mode, a packet whose first byte matches no enabled channel produces no write. A packet that ends before its second byte also produces no write.
- R4: In promiscuous mode, every packet that is not an RMAP command goes to the lowest-indexed enabled channel, whatever its first byte.
- R5: In promiscuous mode, a packet that ends after one byte is still delivered: the byte, then the end marker. An empty packet delivers only an end marker.
- R6: A channel accepts at most its configured maximum number of data bytes per packet. Further bytes are dropped, and the end marker has trunc_o=1. A packet of exactly the maximum length ends with trunc_o=0. This rule holds in both modes.
- R7: When rmap_en_i=1 and the second byte equals 0x01, the whole packet goes to the RMAP port, in either mode, with no length limit and trunc_o=0.
- R8: When rmap_en_i=0, a packet whose second byte is 0x01 is routed to a channel like any other packet.
- R9: A packet that is discarded because no channel is enabled sets no_chan_o. The flag stays 1 until reset.
- R10: A packet that terminates with an error end (EEP) is delivered with an end marker that has eep_o=1. A packet ended by a normal EOP gives eep_o=0.
- R11: At most one of the channel strobes and the RMAP strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nchar_vld_i | input | 1 | An N-Char is present this cycle |
| nchar_data_i | input | 8 | Data byte of the N-Char |
| nchar_eop_i | input | 1 | The N-Char is a normal end of packet |
| nchar_eep_i | input | 1 | The N-Char is an error end of packet |
| promisc_i | input | 1 | Promiscuous routing enable |
| rmap_en_i | input | 1 | Divert RMAP commands to the handler port |
| chan_en_i | input | NUM_CH | Per-channel enable |
| chan_addr_i | input | 8*NUM_CH | Per-channel node address, channel c in bits [8c+7:8c] |
| chan_max_len_i | input | LEN_W*NUM_CH | Per-channel maximum data bytes per packet |
| ch_wr_o | output | NUM_CH | One-hot write strobe per channel |
| rmap_wr_o | output | 1 | Write strobe to the RMAP handler |
| data_o | output | 8 | Shared data byte (0 with end markers) |
| end_o | output | 1 | The write is an end marker |
| eep_o | output | 1 | The end marker is an error end |
| trunc_o | output | 1 | The end marker closes a truncated packet |
| no_chan_o | output | 1 | Sticky: a packet was lost because no channel was enabled |

## Verification
The bench builds the block with NUM_CH=4, LEN_W=16 and the RMAP handler present. With four channels, two channels can hold the same address, so match priority can be tested. Disabling low channels shows that promiscuous mode picks the lowest channel that is still enabled. Limits of two and three bytes put truncation, and the exactly-at-limit case, within a few characters. The bench sends a long RMAP command through a channel whose limit is low, to show that the RMAP port ignores that limit.

// File: rtl/spw_rx_router_pkg.sv
package spw_rx_router_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_FWD, ST_DROP} rx_state_e;
  typedef enum logic [1:0] {D_NONE, D_CH, D_RMAP} dest_kind_e;
endpackage

// File: rtl/spw_rx_dest_sel.sv
module spw_rx_dest_sel #(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_CH-1:0]   en_i,
  input  logic [NUM_CH*8-1:0] addr_i,
  input  logic [7:0]          key_i,
  output logic                first_vld_o,
  output logic [IDX_W-1:0]    first_idx_o,
  output logic                match_vld_o,
  output logic [IDX_W-1:0]    match_idx_o
);
  logic [NUM_CH-1:0] hit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    assign hit[c] = en_i[c] && (addr_i[c*8 +: 8] == key_i);
  end

  // descending scan so the lowest index wins
  always_comb begin
    first_vld_o = 1'b0;
    first_idx_o = '0;
    match_vld_o = 1'b0;
    match_idx_o = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (en_i[c]) begin
        first_vld_o = 1'b1;
        first_idx_o = IDX_W'(c);
      end
      if (hit[c]) begin
        match_vld_o = 1'b1;
        match_idx_o = IDX_W'(c);
      end
    end
  end
endmodule

// File: rtl/spw_rx_len_guard.sv
module spw_rx_len_guard #(
  parameter int LEN_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             req_i,
  input  logic [LEN_W-1:0] max_i,
  output logic             ok_o,
  output logic             trunc_o
);
  logic [LEN_W-1:0] cnt_q;
  logic             trunc_q;

  assign ok_o    = cnt_q < max_i;
  assign trunc_o = trunc_q | (req_i & ~ok_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      trunc_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      trunc_q <= 1'b0;
    end else if (req_i) begin
      if (ok_o) cnt_q   <= cnt_q + 1'b1;
      else      trunc_q <= 1'b1;
    end
  end
endmodule

// File: rtl/spw_rx_router.sv
module spw_rx_router
  import spw_rx_router_pkg::*;
#(
  parameter int         NUM_CH       = 4,
  parameter int         LEN_W        = 24,
  parameter bit         RMAP_PRESENT = 1'b1,
  parameter logic [7:0] RMAP_PROTO   = 8'h01
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    nchar_vld_i,
  input  logic [7:0]              nchar_data_i,
  input  logic                    nchar_eop_i,
  input  logic                    nchar_eep_i,
  input  logic                    promisc_i,
  input  logic                    rmap_en_i,
  input  logic [NUM_CH-1:0]       chan_en_i,
  input  logic [NUM_CH*8-1:0]     chan_addr_i,
  input  logic [NUM_CH*LEN_W-1:0] chan_max_len_i,
  output logic [NUM_CH-1:0]       ch_wr_o,
  output logic                    rmap_wr_o,
  output logic [7:0]              data_o,
  output logic                    end_o,
  output logic                    eep_o,
  output logic                    trunc_o,
  output logic                    no_chan_o
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  rx_state_e        st_q, st_d;
  dest_kind_e       dkind_q, dkind_d;
  logic [IDX_W-1:0] didx_q, didx_d;
  logic [7:0]       hold_q, hold_d;

  logic             is_data, is_term, is_rmap;
  logic             first_vld, match_vld;
  logic [IDX_W-1:0] first_idx, match_idx;
  logic             byte_go, term_go, nc_set, g_clr, g_req, g_ok, g_trunc;
  logic             term_trunc;
  logic [LEN_W-1:0] max_sel;

  logic             pend_q, pend_eep_q, pend_trunc_q;
  dest_kind_e       pend_kind_q;
  logic [IDX_W-1:0] pend_idx_q;
  logic             no_chan_q;

  assign is_data = nchar_vld_i & ~(nchar_eop_i | nchar_eep_i);
  assign is_term = nchar_vld_i &  (nchar_eop_i | nchar_eep_i);
  assign is_rmap = RMAP_PRESENT && rmap_en_i && (nchar_data_i == RMAP_PROTO);

  spw_rx_dest_sel #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_sel (
    .en_i        (chan_en_i),
    .addr_i      (chan_addr_i),
    .key_i       (hold_q),
    .first_vld_o (first_vld),
    .first_idx_o (first_idx),
    .match_vld_o (match_vld),
    .match_idx_o (match_idx)
  );

  always_comb begin
    st_d    = st_q;
    hold_d  = hold_q;
    dkind_d = dkind_q;
    didx_d  = didx_q;
    byte_go = 1'b0;
    term_go = 1'b0;
    nc_set  = 1'b0;
    g_clr   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (is_data) begin
          hold_d = nchar_data_i;
          st_d   = ST_HOLD;
          g_clr  = 1'b1;
        end else if (is_term && promisc_i) begin
          if (first_vld) begin
            dkind_d = D_CH;
            didx_d  = first_idx;
            term_go = 1'b1;
          end else begin
            nc_set = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (is_data) begin
          hold_d = nchar_data_i;
          st_d   = ST_FWD;
          if (is_rmap) begin
            dkind_d = D_RMAP;
          end else if (promisc_i) begin
            if (first_vld) begin
              dkind_d = D_CH;
              didx_d  = first_idx;
            end else begin
              dkind_d = D_NONE;
              st_d    = ST_DROP;
              nc_set  = 1'b1;
            end
          end else if (match_vld) begin
            dkind_d = D_CH;
            didx_d  = match_idx;
          end else begin
            dkind_d = D_NONE;
            st_d    = ST_DROP;
            nc_set  = ~|chan_en_i;
          end
          byte_go = (dkind_d != D_NONE);
        end else if (is_term) begin
          st_d = ST_IDLE;
          // early end: kept only in promiscuous mode
          if (promisc_i) begin
            if (first_vld) begin
              dkind_d = D_CH;
              didx_d  = first_idx;
              byte_go = 1'b1;
              term_go = 1'b1;
            end else begin
              nc_set = 1'b1;
            end
          end
        end
      end
      ST_FWD: begin
        if (is_data) begin
          hold_d  = nchar_data_i;
          byte_go = 1'b1;
        end else if (is_term) begin
          byte_go = 1'b1;
          term_go = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      ST_DROP: begin
        if (is_term) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign max_sel = chan_max_len_i[int'(didx_d)*LEN_W +: LEN_W];
  assign g_req   = byte_go && (dkind_d == D_CH);

  spw_rx_len_guard #(.LEN_W(LEN_W)) u_guard (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (g_clr),
    .req_i   (g_req),
    .max_i   (max_sel),
    .ok_o    (g_ok),
    .trunc_o (g_trunc)
  );

  assign term_trunc = (st_q == ST_IDLE || dkind_d != D_CH) ? 1'b0 : g_trunc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      hold_q  <= '0;
      dkind_q <= D_NONE;
      didx_q  <= '0;
    end else begin
      st_q    <= st_d;
      hold_q  <= hold_d;
      dkind_q <= dkind_d;
      didx_q  <= didx_d;
    end
  end

  // end markers trail the flushed last byte by one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= 1'b0;
      pend_eep_q   <= 1'b0;
      pend_trunc_q <= 1'b0;
      pend_kind_q  <= D_NONE;
      pend_idx_q   <= '0;
      no_chan_q    <= 1'b0;
    end else begin
      pend_q    <= term_go;
      no_chan_q <= no_chan_q | nc_set;
      if (term_go) begin
        pend_eep_q   <= nchar_eep_i;
        pend_trunc_q <= term_trunc;
        pend_kind_q  <= dkind_d;
        pend_idx_q   <= didx_d;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_wr_o   <= '0;
      rmap_wr_o <= 1'b0;
      data_o    <= '0;
      end_o     <= 1'b0;
      eep_o     <= 1'b0;
      trunc_o   <= 1'b0;
    end else begin
      ch_wr_o   <= '0;
      rmap_wr_o <= 1'b0;
      data_o    <= '0;
      end_o     <= 1'b0;
      eep_o     <= 1'b0;
      trunc_o   <= 1'b0;
      if (pend_q) begin
        end_o   <= 1'b1;
        eep_o   <= pend_eep_q;
        trunc_o <= pend_trunc_q;
        if (pend_kind_q == D_RMAP) begin
          rmap_wr_o <= 1'b1;
        end else begin
          for (int c = 0; c < NUM_CH; c++) ch_wr_o[c] <= (IDX_W'(c) == pend_idx_q);
        end
      end else if (byte_go && (dkind_d == D_RMAP || g_ok)) begin
        data_o <= hold_q;
        if (dkind_d == D_RMAP) begin
          rmap_wr_o <= 1'b1;
        end else begin
          for (int c = 0; c < NUM_CH; c++) ch_wr_o[c] <= (IDX_W'(c) == didx_d);
        end
      end
    end
  end

  assign no_chan_o = no_chan_q;
endmodule

// File: rtl/spw_rx_router_chk.sv
module spw_rx_router_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              promisc_i,
  input logic [NUM_CH-1:0] chan_en_i,
  input logic [NUM_CH-1:0] ch_wr_o,
  input logic              rmap_wr_o,
  input logic              end_o,
  input logic              eep_o,
  input logic              trunc_o,
  input logic              no_chan_o
);
  logic [NUM_CH-1:0] low_en;
  assign low_en = chan_en_i & (~chan_en_i + NUM_CH'(1));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (ch_wr_o == '0 && !rmap_wr_o && !no_chan_o);
    end
  end

  assert_one_dest_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rmap_wr_o, ch_wr_o}));

  // config is held steady around packets
  assert_promisc_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (promisc_i && $stable(promisc_i) && $stable(chan_en_i) && (|ch_wr_o))
      |-> (ch_wr_o == low_en));

  assert_trunc_on_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trunc_o |-> (end_o && (|ch_wr_o)));

  assert_rmap_untrunc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rmap_wr_o |-> !trunc_o);

  assert_no_chan_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_chan_o |=> no_chan_o);

  assert_eep_on_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eep_o |-> end_o);
endmodule

bind spw_rx_router spw_rx_router_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .promisc_i (promisc_i),
  .chan_en_i (chan_en_i),
  .ch_wr_o   (ch_wr_o),
  .rmap_wr_o (rmap_wr_o),
  .end_o     (end_o),
  .eep_o     (eep_o),
  .trunc_o   (trunc_o),
  .no_chan_o (no_chan_o)
);

// File: tb/tb_spw_rx_router.sv
module tb_spw_rx_router;
  localparam int NCH  = 4;
  localparam int LW   = 16;
  localparam int NDST = NCH + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            vld = 1'b0, eop = 1'b0, eep = 1'b0;
  logic [7:0]      din = '0;
  logic            promisc = 1'b0, rmap_en = 1'b0;
  logic [NCH-1:0]  chan_en = '0;
  logic [NCH*8-1:0]  chan_addr = {8'h30, 8'h20, 8'h20, 8'h10};
  logic [NCH*LW-1:0] chan_max = {NCH{16'd100}};
  logic [NCH-1:0]  ch_wr;
  logic            rmap_wr, end_f, eep_f, trunc_f, no_chan;
  logic [7:0]      dout;

  int checks = 0, errors = 0, multi_wr = 0;
  logic [10:0] log_mem [NDST][512];
  int          log_n   [NDST];
  int          base    [NDST];
  logic [7:0]  pkt [32];

  always #5 clk = ~clk;

  spw_rx_router #(.NUM_CH(NCH), .LEN_W(LW), .RMAP_PRESENT(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .nchar_vld_i(vld), .nchar_data_i(din),
    .nchar_eop_i(eop), .nchar_eep_i(eep), .promisc_i(promisc), .rmap_en_i(rmap_en),
    .chan_en_i(chan_en), .chan_addr_i(chan_addr), .chan_max_len_i(chan_max),
    .ch_wr_o(ch_wr), .rmap_wr_o(rmap_wr), .data_o(dout), .end_o(end_f),
    .eep_o(eep_f), .trunc_o(trunc_f), .no_chan_o(no_chan)
  );

  initial for (int k = 0; k < NDST; k++) log_n[k] = 0;

  // output monitor: log entry = {end, eep, trunc, data}
  always @(negedge clk) begin
    if (rst_n && (rmap_wr || (|ch_wr))) begin
      int d;
      d = rmap_wr ? NCH : 0;
      for (int c = 0; c < NCH; c++) if (ch_wr[c]) d = c;
      if ($countones({rmap_wr, ch_wr}) > 1) multi_wr++;
      if (log_n[d] < 512) log_mem[d][log_n[d]] = {end_f, eep_f, trunc_f, dout};
      log_n[d]++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic snap();
    for (int k = 0; k < NDST; k++) base[k] = log_n[k];
  endtask

  task automatic send_pkt(input int n, input bit err_end);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); vld = 1'b1; din = pkt[i]; eop = 1'b0; eep = 1'b0;
    end
    @(negedge clk); vld = 1'b1; din = '0; eop = !err_end; eep = err_end;
    @(negedge clk); vld = 1'b0; eop = 1'b0; eep = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_pkt(input int d, input int nb, input bit x_eep, input bit x_trunc, input string req);
    int got;
    got = log_n[d] - base[d];
    chk(got == nb + 1, req, $sformatf("entries on dest %0d", d), got, nb + 1);
    if (got == nb + 1) begin
      for (int i = 0; i < nb; i++)
        chk(log_mem[d][base[d] + i] == {3'b000, pkt[i]}, req, $sformatf("byte %0d", i),
            int'(log_mem[d][base[d] + i]), int'({3'b000, pkt[i]}));
      chk(log_mem[d][base[d] + nb] == {1'b1, x_eep, x_trunc, 8'h00}, req, "end marker",
          int'(log_mem[d][base[d] + nb]), int'({1'b1, x_eep, x_trunc, 8'h00}));
    end
  endtask

  task automatic check_none(input int d, input string req);
    chk(log_n[d] == base[d], req, $sformatf("writes on dest %0d", d), log_n[d] - base[d], 0);
  endtask

  task automatic cfg(input bit p, input bit r, input logic [NCH-1:0] en);
    @(negedge clk); promisc = p; rmap_en = r; chan_en = en;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk(ch_wr == '0 && !rmap_wr, "R1", "strobes in reset", {rmap_wr, ch_wr}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ch_wr == '0 && !rmap_wr, "R1", "strobes after reset", {rmap_wr, ch_wr}, 0);
    chk(!no_chan, "R1", "no_chan after reset", no_chan, 0);
  endtask

  task automatic t_addr_match();
    cfg(0, 0, 4'b1111);
    pkt[0] = 8'h20; pkt[1] = 8'h55; pkt[2] = 8'h66; pkt[3] = 8'h77;
    snap(); send_pkt(4, 0);
    check_pkt(1, 4, 0, 0, "R2");
    check_none(2, "R2"); check_none(0, "R2");
    cfg(0, 0, 4'b1101);
    snap(); send_pkt(4, 0);
    check_pkt(2, 4, 0, 0, "R2");
    check_none(1, "R2");
  endtask

  task automatic t_unmatched();
    cfg(0, 0, 4'b1111);
    pkt[0] = 8'h99; pkt[1] = 8'h01; pkt[2] = 8'h02;
    snap(); send_pkt(3, 0);
    for (int k = 0; k < NDST; k++) check_none(k, "R3");
    pkt[0] = 8'h10;
    snap(); send_pkt(1, 0);
    check_none(0, "R3");
  endtask

  task automatic t_promisc();
    cfg(1, 0, 4'b1100);
    pkt[0] = 8'h99; pkt[1] = 8'h02; pkt[2] = 8'h03;
    snap(); send_pkt(3, 0);
    check_pkt(2, 3, 0, 0, "R4");
    check_none(3, "R4");
    pkt[0] = 8'h30;
    snap(); send_pkt(3, 0);
    check_pkt(2, 3, 0, 0, "R4");
  endtask

  task automatic t_promisc_early();
    cfg(1, 0, 4'b1100);
    pkt[0] = 8'h42;
    snap(); send_pkt(1, 0);
    check_pkt(2, 1, 0, 0, "R5");
    snap(); send_pkt(0, 0);
    check_pkt(2, 0, 0, 0, "R5");
  endtask

  task automatic t_trunc();
    cfg(0, 0, 4'b1111);
    chan_max[0 +: LW] = 16'd3;
    pkt[0] = 8'h10; pkt[1] = 8'hA1; pkt[2] = 8'hA2; pkt[3] = 8'hA3; pkt[4] = 8'hA4; pkt[5] = 8'hA5;
    snap(); send_pkt(6, 0);
    check_pkt(0, 3, 0, 1, "R6");
    snap(); send_pkt(3, 0);
    check_pkt(0, 3, 0, 0, "R6");
    cfg(1, 0, 4'b0001);
    chan_max[0 +: LW] = 16'd2;
    pkt[0] = 8'h77;
    snap(); send_pkt(5, 0);
    check_pkt(0, 2, 0, 1, "R6");
    chan_max[0 +: LW] = 16'd100;
  endtask

  task automatic t_rmap();
    cfg(0, 1, 4'b1111);
    chan_max[0 +: LW] = 16'd3;
    pkt[0] = 8'h10; pkt[1] = 8'h01;
    for (int i = 2; i < 8; i++) pkt[i] = 8'(8'h10 + i);
    snap(); send_pkt(8, 0);
    check_pkt(NCH, 8, 0, 0, "R7");
    check_none(0, "R7");
    cfg(1, 1, 4'b1111);
    snap(); send_pkt(8, 0);
    check_pkt(NCH, 8, 0, 0, "R7");
    check_none(0, "R7");
    chan_max[0 +: LW] = 16'd100;
  endtask

  task automatic t_rmap_off();
    cfg(0, 0, 4'b1111);
    pkt[0] = 8'h20; pkt[1] = 8'h01; pkt[2] = 8'hAA;
    snap(); send_pkt(3, 0);
    check_pkt(1, 3, 0, 0, "R8");
    check_none(NCH, "R8");
  endtask

  task automatic t_eep();
    cfg(0, 0, 4'b1111);
    pkt[0] = 8'h30; pkt[1] = 8'h5A;
    snap(); send_pkt(2, 1);
    check_pkt(3, 2, 1, 0, "R10");
    snap(); send_pkt(2, 0);
    check_pkt(3, 2, 0, 0, "R10");
  endtask

  task automatic t_nochan();
    chk(!no_chan, "R9", "no_chan before loss", no_chan, 0);
    cfg(0, 0, 4'b0000);
    pkt[0] = 8'h10; pkt[1] = 8'h11;
    snap(); send_pkt(2, 0);
    for (int k = 0; k < NDST; k++) check_none(k, "R9");
    chk(no_chan, "R9", "no_chan set", no_chan, 1);
    cfg(0, 0, 4'b1111);
    snap(); send_pkt(2, 0);
    check_pkt(0, 2, 0, 0, "R9");
    chk(no_chan, "R9", "no_chan sticky", no_chan, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_addr_match();
    t_unmatched();
    t_promisc();
    t_promisc_early();
    t_trunc();
    t_rmap();
    t_rmap_off();
    t_eep();
    t_nochan();
    chk(multi_wr == 0, "R11", "cycles with several strobes", multi_wr, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule